// File: doc/BRIEF.md
# A/D Conversion Trigger and Transfer Controller

This block runs one 12-bit analog-to-digital conversion at a time behind a byte-wide host register bus. A conversion is started in one of three ways, and a field in the control register picks which: a host write to offset 0, a rising edge on the external trigger pin, or a pulse from a pacer. In pacer mode an optional gate holds pacer pulses back until the external trigger pin is high. The converter is modelled as a fixed latency of `CONV_CYCLES` clocks. At the end of that time the sample on `adc_sample` is captured.

Each result is stored together with the 4-bit channel number that was present on `chan_sel` when the conversion started. The host reads the result as two bytes. It learns that a result is ready in one of three ways: by polling a data-valid status bit, by a level interrupt raised for each conversion, or by two DMA request pulses per conversion, one for each result byte. A trigger that arrives while a conversion is running is dropped.

Register map (`bus_addr`):

| Offset | Read | Write |
|---|---|---|
| 0 | low result byte | software trigger |
| 1 | high result byte | no effect |
| 2 | status | clears data-valid and the interrupt |
| 3 | control | control |

Top module: `adc_seq_ctrl`

## Requirements
- R1: While the trigger-source field is 00 or 01, a bus write of any value to offset 0 starts a conversion. Busy (status bit 0) is 1 from the clock edge that takes the write until `CONV_CYCLES` clocks later.
- R2: A read at offset 0 returns result bits 3..0 on data bits 7..4, and on data bits 3..0 the channel number that `chan_sel` held when the conversion was accepted.
- R3: A read at offset 1 returns result bits 11..4 of the sample that was on `adc_sample` at the edge where busy falls.
- R4: Data-valid (status bit 1) is set on the edge where busy falls. It stays set until any bus write to offset 2. Status bits 7..2 read 0.
- R5: With trigger-source 10, a rising edge on `ext_trig` starts a conversion. The edge passes through a two-flop synchroniser, so busy rises on the third clock edge after the pin rises. In this mode a write to offset 0 starts nothing.
- R6: With trigger-source 11, a one-cycle `pacer_pulse` starts a conversion. When the gate bit (control bit 7) is 1, pacer pulses are ignored while the synchronised `ext_trig` is low.
- R7: When a conversion finishes with interrupt enable (control bit 6) at 1 and DMA enable (control bit 2) at 0, `irq` goes high and stays high until a write to offset 2. `irq_level` always shows control bits 5..3.
- R8: When a conversion finishes with DMA enable at 1, `dma_req` pulses high for one cycle on the clock after the result is stored, and again two cycles later. In this case `irq` stays low.
- R9: A trigger of any kind that arrives while busy is 1 is ignored. It changes neither the result nor the channel tag, and it does not start a second conversion.
- R10: After reset, busy, data-valid, `irq` and `dma_req` are 0 and the control register reads 0. Control bits 7..0 read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register offset for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ext_trig | input | 1 | Asynchronous external trigger and pacer gate |
| pacer_pulse | input | 1 | One-cycle pacer tick |
| chan_sel | input | 4 | Channel number of the current input, captured at start |
| adc_sample | input | 12 | Converter output, captured at completion |
| irq | output | 1 | Conversion-complete interrupt (level) |
| irq_level | output | 3 | Interrupt level field from the control register |
| dma_req | output | 1 | DMA request pulses, two per conversion |

## Verification
The checker tests these properties on every cycle:
- a pending interrupt always has data-valid set;
- an interrupt only rises after an interrupt-mode completion;
- DMA pulses never occur on two cycles in a row;
- data-valid holds until a status write;
- busy falling always leaves data-valid set;
- the captured channel tag does not move during a conversion.

Some behaviour needs the bench's scenarios instead:
- the exact busy window;
- the synchroniser delay on the external trigger;
- the pacer gate;
- the byte packing of random samples;
- the spacing of the two DMA requests;
- the proof that triggers during busy, or a software trigger in external mode, leave no trace.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int SAMPLE_W = 12;
    localparam int TAG_W    = 4;

    typedef enum logic [1:0] {
        SRC_SOFT_A = 2'b00,
        SRC_SOFT_B = 2'b01,
        SRC_EXT    = 2'b10,
        SRC_PACER  = 2'b11
    } trig_src_e;

    typedef struct packed {
        logic       pacer_gate;
        logic       irq_en;
        logic [2:0] irq_lvl;
        logic       dma_en;
        trig_src_e  src;
    } ctrl_t;

    typedef struct packed {
        ctrl_t               ctrl;
        logic                valid;
        logic                irq;
        logic [SAMPLE_W-1:0] result;
        logic [TAG_W-1:0]    tag;
        logic [TAG_W-1:0]    run_tag;
    } core_t;
endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LEN-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int CONV_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(CONV_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.busy) begin
            if (t_q.cnt == '0) t_d.busy = 1'b0;
            else               t_d.cnt  = t_q.cnt - 1'b1;
        end else if (start) begin
            t_d.busy = 1'b1;
            t_d.cnt  = LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy = t_q.busy;
    assign done = t_q.busy && (t_q.cnt == '0);
endmodule

// File: rtl/adc_dma_pair.sv
module adc_dma_pair (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic req
);
    logic [1:0] ph_d, ph_q;

    always_comb begin
        if (start)            ph_d = 2'd1;
        else if (ph_q != 2'd0) ph_d = ph_q + 2'd1;
        else                  ph_d = 2'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= 2'd0;
        else        ph_q <= ph_d;
    end

    assign req = ph_q[0];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CONV_CYCLES = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic                ext_trig,
    input  logic                pacer_pulse,
    input  logic [TAG_W-1:0]    chan_sel,
    input  logic [SAMPLE_W-1:0] adc_sample,
    output logic                irq,
    output logic [2:0]          irq_level,
    output logic                dma_req
);
    localparam logic [1:0] OFS_LO   = 2'd0;
    localparam logic [1:0] OFS_HI   = 2'd1;
    localparam logic [1:0] OFS_STAT = 2'd2;
    localparam logic [1:0] OFS_CTRL = 2'd3;

    core_t s_d, s_q;
    logic  ext_level, ext_rise;
    logic  busy, done;
    logic  trig_req, accept, dma_start;
    logic  wr_stat, wr_ctrl, wr_soft;

    adc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_trig),
        .level(ext_level), .rise(ext_rise)
    );

    adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(accept),
        .busy(busy), .done(done)
    );

    adc_dma_pair u_dma (
        .clk(clk), .rst_n(rst_n), .start(dma_start), .req(dma_req)
    );

    assign wr_soft = bus_wr && (bus_addr == OFS_LO);
    assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);

    always_comb begin
        unique case (s_q.ctrl.src)
            SRC_SOFT_A, SRC_SOFT_B: trig_req = wr_soft;
            SRC_EXT:                trig_req = ext_rise;
            SRC_PACER:              trig_req = pacer_pulse &&
                                               (!s_q.ctrl.pacer_gate || ext_level);
            default:                trig_req = 1'b0;
        endcase
    end

    assign accept    = trig_req && !busy;
    assign dma_start = done && s_q.ctrl.dma_en;

    always_comb begin
        s_d = s_q;
        if (wr_ctrl) s_d.ctrl = ctrl_t'(bus_wdata);
        if (accept)  s_d.run_tag = chan_sel;
        if (wr_stat) begin
            s_d.valid = 1'b0;
            s_d.irq   = 1'b0;
        end
        if (done) begin
            s_d.result = adc_sample;
            s_d.tag    = s_q.run_tag;
            s_d.valid  = 1'b1;
            if (s_q.ctrl.irq_en && !s_q.ctrl.dma_en) s_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (bus_addr)
            OFS_LO:   bus_rdata = {s_q.result[3:0], s_q.tag};
            OFS_HI:   bus_rdata = s_q.result[11:4];
            OFS_STAT: bus_rdata = {6'b0, s_q.valid, busy};
            OFS_CTRL: bus_rdata = s_q.ctrl;
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign irq       = s_q.irq;
    assign irq_level = s_q.ctrl.irq_lvl;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       dma_req,
    input logic       busy,
    input logic       valid,
    input logic       wr_stat,
    input logic       irq_en,
    input logic       dma_en,
    input logic [3:0] run_tag
);
    AST_IRQ_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> valid); // R7
    AST_IRQ_RISE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_en && !dma_en)); // R7
    AST_DMA_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req); // R8
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !wr_stat) |=> valid); // R4
    AST_DONE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> valid); // R4
    AST_TAG_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(run_tag)); // R9
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .dma_req(dma_req),
    .busy(busy), .valid(s_q.valid), .wr_stat(wr_stat),
    .irq_en(s_q.ctrl.irq_en), .dma_en(s_q.ctrl.dma_en),
    .run_tag(s_q.run_tag)
);

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        ext_trig = 1'b0;
    logic        pacer_pulse = 1'b0;
    logic [3:0]  chan_sel = 4'h0;
    logic [11:0] adc_sample = 12'h000;
    logic        irq;
    logic [2:0]  irq_level;
    logic        dma_req;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    adc_seq_ctrl #(.CONV_CYCLES(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
        .pacer_pulse(pacer_pulse), .chan_sel(chan_sel), .adc_sample(adc_sample),
        .irq(irq), .irq_level(irq_level), .dma_req(dma_req)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] exp_lo(logic [11:0] s, logic [3:0] c);
        return {s[3:0], c};
    endfunction
    function automatic logic [7:0] exp_hi(logic [11:0] s);
        return s[11:4];
    endfunction
    function automatic logic [7:0] mk_ctrl(bit gate, bit ie, logic [2:0] lvl,
                                           bit de, logic [1:0] src);
        return {gate, ie, lvl, de, src};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    // Called at the negedge just after the accepting edge.
    task automatic follow_conv(string req, logic [11:0] s, logic [3:0] c,
                               bit exp_irq, bit exp_dma);
        logic [7:0] rd;
        bus_read(2'd2, rd);
        check({req, " busy rises"}, rd[0], 1'b1);
        repeat (LAT - 1) @(negedge clk);
        bus_read(2'd2, rd);
        check({req, " R1 busy last cycle"}, rd[0], 1'b1);
        @(negedge clk);
        bus_read(2'd2, rd);
        check({req, " R4 status after done"}, rd, 8'h02);
        check({req, " R7 irq"}, irq, exp_irq);
        check({req, " R8 dma first"}, dma_req, exp_dma);
        bus_read(2'd0, rd);
        check({req, " R2 low byte"}, rd, exp_lo(s, c));
        bus_read(2'd1, rd);
        check({req, " R3 high byte"}, rd, exp_hi(s));
        @(negedge clk);
        check({req, " R8 dma gap"}, dma_req, 1'b0);
        @(negedge clk);
        check({req, " R8 dma second"}, dma_req, exp_dma);
        @(negedge clk);
        check({req, " R8 dma end"}, dma_req, 1'b0);
        bus_read(2'd2, rd);
        check({req, " R4 valid held"}, rd[1], 1'b1);
        bus_write(2'd2, 8'hA5);
        bus_read(2'd2, rd);
        check({req, " R4 valid cleared"}, rd[1], 1'b0);
        check({req, " R7 irq cleared"}, irq, 1'b0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [11:0] s;
        logic [3:0] c;
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        bus_read(2'd2, rd); check("R10 status reset", rd, 8'h00);
        bus_read(2'd3, rd); check("R10 ctrl reset", rd, 8'h00);
        check("R10 irq reset", irq, 1'b0);
        check("R10 dma reset", dma_req, 1'b0);
        bus_write(2'd3, 8'hD9);
        bus_read(2'd3, rd); check("R10 ctrl readback", rd, 8'hD9);
        check("R7 irq_level", irq_level, 3'd3);

        // R1 soft trigger, interrupt delivery
        bus_write(2'd3, mk_ctrl(0, 1, 3'd5, 0, 2'b01));
        check("R7 irq_level 5", irq_level, 3'd5);
        adc_sample = 12'hABC; chan_sel = 4'h7;
        bus_write(2'd0, 8'h00);
        follow_conv("R1 soft", 12'hABC, 4'h7, 1, 0);

        // R9 triggers during busy ignored
        adc_sample = 12'h3C5; chan_sel = 4'h2;
        bus_write(2'd0, 8'h11);
        chan_sel = 4'hE;
        bus_write(2'd0, 8'h22);
        repeat (LAT - 1) @(negedge clk);
        bus_read(2'd2, rd); check("R9 busy ended once", rd, 8'h02);
        bus_read(2'd0, rd); check("R9 tag kept", rd, exp_lo(12'h3C5, 4'h2));
        @(negedge clk);
        bus_read(2'd2, rd); check("R9 no second conversion", rd[0], 1'b0);
        bus_write(2'd2, 8'h00);

        // R5 external mode: software write ignored
        bus_write(2'd3, mk_ctrl(0, 0, 3'd0, 1, 2'b10));
        adc_sample = 12'h111;
        bus_write(2'd0, 8'hFF);
        repeat (2) @(negedge clk);
        bus_read(2'd2, rd); check("R5 soft ignored in ext mode", rd, 8'h00);
        // R5 external edge with synchroniser delay, DMA delivery
        adc_sample = 12'h5A6; chan_sel = 4'h9;
        ext_trig = 1'b1;
        repeat (2) @(negedge clk);
        bus_read(2'd2, rd); check("R5 not yet busy", rd[0], 1'b0);
        @(negedge clk);
        follow_conv("R5 ext", 12'h5A6, 4'h9, 0, 1);
        ext_trig = 1'b0;
        repeat (4) @(negedge clk);

        // R6 pacer gate blocks while ext low
        bus_write(2'd3, mk_ctrl(1, 1, 3'd1, 0, 2'b11));
        pacer_pulse = 1'b1; @(negedge clk); pacer_pulse = 1'b0;
        @(negedge clk);
        bus_read(2'd2, rd); check("R6 gated pacer ignored", rd, 8'h00);
        ext_trig = 1'b1;
        repeat (3) @(negedge clk);
        adc_sample = 12'hF0F; chan_sel = 4'hC;
        pacer_pulse = 1'b1; @(negedge clk); pacer_pulse = 1'b0;
        follow_conv("R6 pacer gated open", 12'hF0F, 4'hC, 1, 0);
        ext_trig = 1'b0;
        repeat (4) @(negedge clk);

        // random mix
        for (int i = 0; i < 40; i++) begin
            int m;
            bit de, ie;
            m = $urandom_range(0, 2);
            de = $urandom_range(0, 1);
            ie = $urandom_range(0, 1);
            s = 12'($urandom);
            c = 4'($urandom);
            adc_sample = s; chan_sel = c;
            if (m == 0) begin
                bus_write(2'd3, mk_ctrl(0, ie, 3'd2, de, 2'($urandom_range(0, 1))));
                bus_write(2'd0, 8'($urandom));
                follow_conv("R1 rand soft", s, c, ie && !de, de);
            end else if (m == 1) begin
                bus_write(2'd3, mk_ctrl(0, ie, 3'd4, de, 2'b10));
                ext_trig = 1'b1;
                repeat (3) @(negedge clk);
                follow_conv("R5 rand ext", s, c, ie && !de, de);
                ext_trig = 1'b0;
                repeat (3) @(negedge clk);
            end else begin
                bus_write(2'd3, mk_ctrl(0, ie, 3'd6, de, 2'b11));
                pacer_pulse = 1'b1; @(negedge clk); pacer_pulse = 1'b0;
                follow_conv("R6 rand pacer", s, c, ie && !de, de);
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule